// File: doc/BRIEF.md
# Accumulator ALU with Five Status Flags

This block is the arithmetic and logic unit of a small 8-bit processor core. The accumulator is always the first operand and normally receives the result. The second operand sits in a private operand register that the surrounding sequencer loads through the operand-load strobe. Software has no access to it. A start strobe names one of twelve operations. One clock later the block publishes the new accumulator and the new status flags, and raises `done_o` for a single cycle.

The status word holds five bits: sign, zero, nibble carry, even parity and carry. Two of the operations step a register other than the accumulator up or down by one. They take the private operand, return the result on a separate side port and update every flag except carry. Compare computes a subtraction for its flags only. Decoding instructions, decimal adjust and the general register file are handled by neighbouring blocks.

Top module: `acc_alu_top`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the private operand register, the flags, the side result and `done_o`.
- R2: When `opnd_ld_i` is high at a clock edge, the private operand register takes `opnd_i`. Loading changes no output. An operation started with `start_i` reads the operand register as it stood before that edge. `done_o` is high exactly in the cycle after a start and low otherwise. The accumulator, flags and side port change only at the edge that ends a start cycle.
- R3: The arithmetic opcodes are 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow). Each writes the result modulo 256 to the accumulator. For addition, carry is the carry out of bit 7. For subtraction, carry is 1 when a borrow leaves bit 7. For opcodes 1 and 3, the current carry flag is the incoming carry or borrow.
- R4: Opcode 4 (AND), opcode 5 (XOR) and opcode 6 (OR) combine the accumulator with the operand bitwise, write the accumulator, and clear both carry and nibble carry.
- R5: Opcode 7 (compare) sets all five flags exactly as opcode 2 would and leaves the accumulator unchanged.
- R6: Opcode 8 adds one to the accumulator and opcode 9 subtracts one, wrapping modulo 256. Both leave the carry flag unchanged.
- R7: Opcode 10 adds one to the private operand and opcode 11 subtracts one. The result goes to `side_o`, and the accumulator and carry stay unchanged. Sign, zero, nibble carry and parity all follow the side result.
- R8: The flag word `flags_o` is ordered {sign, zero, nibble carry, parity, carry}, with carry at bit 0. Sign is bit 7 of the result. Zero is 1 exactly when the 8-bit result is 0. Parity is 1 exactly when the result has an even number of 1 bits.
- R9: Nibble carry is 1 when an addition carries from bit 3 into bit 4. For subtraction and decrement, it is 1 when the low nibble needs a borrow.
- R10: Opcodes 12 to 15 do nothing except pulse `done_o`. The accumulator, flags and side result keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code, sampled with `start_i` |
| opnd_i | input | 8 | Second operand value |
| opnd_ld_i | input | 1 | Writes `opnd_i` into the private operand register |
| start_i | input | 1 | Begins the operation named by `op_i` |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | {sign, zero, nibble carry, parity, carry} |
| side_o | output | 8 | Result of the non-accumulator increment and decrement |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default widths: an 8-bit datapath split into 4-bit nibbles. At that size every opcode, reserved codes included, can be swept across all 256 operand values. The sweep runs several passes with the accumulator and carry chained from one operation to the next. As a result, each arithmetic opcode meets both carry-in states, both nibble-boundary directions, wrap at 0x00 and 0xFF, and zero and odd-parity results. A bench-side integer model predicts every output. A reset issued in the middle of the run and an operation started on the freshly cleared operand register check the clearing behaviour.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_INA = 4'd8,
        OP_DCA = 4'd9,
        OP_INR = 4'd10,
        OP_DCR = 4'd11
    } alu_op_e;

    // where the result of an operation is written
    typedef enum logic [1:0] {
        WB_NONE,
        WB_ACC,
        WB_FLAGS_ONLY,
        WB_SIDE
    } wb_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_XOR,
        LG_OR
    } logic_e;

    // bit 4 .. bit 0
    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              sub;
        logic              cin;
        logic              is_logic;
        logic_e            lop;
        logic              keep_cy;
        wb_e               wb;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] logic_unit(
        input logic [DATA_W-1:0] a,
        input logic [DATA_W-1:0] b,
        input logic_e            sel
    );
        case (sel)
            LG_AND:  logic_unit = a & b;
            LG_XOR:  logic_unit = a ^ b;
            default: logic_unit = a | b;
        endcase
    endfunction

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        even_parity = ~(^v);
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    acc,
    input  logic [W-1:0]    tmp,
    input  logic            cy,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl          = '0;
        ctrl.a        = acc;
        ctrl.b        = tmp;
        ctrl.lop      = LG_AND;
        ctrl.wb       = WB_NONE;
        case (op)
            4'(OP_ADD): ctrl.wb = WB_ACC;
            4'(OP_ADC): begin
                ctrl.cin = cy;
                ctrl.wb  = WB_ACC;
            end
            4'(OP_SUB): begin
                ctrl.sub = 1'b1;
                ctrl.wb  = WB_ACC;
            end
            4'(OP_SBB): begin
                ctrl.sub = 1'b1;
                ctrl.cin = cy;
                ctrl.wb  = WB_ACC;
            end
            4'(OP_CMP): begin
                ctrl.sub = 1'b1;
                ctrl.wb  = WB_FLAGS_ONLY;
            end
            4'(OP_AND): begin
                ctrl.is_logic = 1'b1;
                ctrl.lop      = LG_AND;
                ctrl.wb       = WB_ACC;
            end
            4'(OP_XOR): begin
                ctrl.is_logic = 1'b1;
                ctrl.lop      = LG_XOR;
                ctrl.wb       = WB_ACC;
            end
            4'(OP_OR): begin
                ctrl.is_logic = 1'b1;
                ctrl.lop      = LG_OR;
                ctrl.wb       = WB_ACC;
            end
            4'(OP_INA), 4'(OP_DCA), 4'(OP_INR), 4'(OP_DCR): begin
                // step by one: operand zero with carry or borrow forced in
                ctrl.a       = (op == 4'(OP_INR) || op == 4'(OP_DCR)) ? tmp : acc;
                ctrl.b       = '0;
                ctrl.sub     = (op == 4'(OP_DCA) || op == 4'(OP_DCR));
                ctrl.cin     = 1'b1;
                ctrl.keep_cy = 1'b1;
                ctrl.wb      = (op == 4'(OP_INR) || op == 4'(OP_DCR)) ? WB_SIDE : WB_ACC;
            end
            default: ctrl.wb = WB_NONE;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu8_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,     // carry in (add) or borrow in (sub)
    output logic [W-1:0] sum,
    output logic         co,      // carry out (add) or borrow out (sub)
    output logic         co_nib   // same, across the low nibble boundary
);

    localparam int HW = W - N;

    logic [W-1:0] y;
    logic         c0;
    logic [N:0]   lo;
    logic [HW:0]  hi;

    always_comb begin
        y   = sub ? ~b : b;
        c0  = sub ? ~cin : cin;
        lo  = {1'b0, a[N-1:0]} + {1'b0, y[N-1:0]} + {{N{1'b0}}, c0};
        hi  = {1'b0, a[W-1:N]} + {1'b0, y[W-1:N]} + {{HW{1'b0}}, lo[N]};
        sum = {hi[HW-1:0], lo[N-1:0]};
        co     = hi[HW] ^ sub;
        co_nib = lo[N]  ^ sub;
    end

endmodule

// File: rtl/alu_flagger.sv
module alu_flagger
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    input  logic         co,
    input  logic         co_nib,
    input  logic         is_logic,
    input  logic         keep_cy,
    input  logic         cy_old,
    output flags_t       nf
);

    always_comb begin
        nf.s  = res[W-1];
        nf.z  = (res == '0);
        nf.p  = even_parity(res);
        nf.ac = is_logic ? 1'b0 : co_nib;
        if (is_logic)
            nf.cy = 1'b0;
        else if (keep_cy)
            nf.cy = cy_old;
        else
            nf.cy = co;
    end

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import alu8_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      opnd_i,
    input  logic              opnd_ld_i,
    input  logic              start_i,
    output logic [W-1:0]      acc_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [W-1:0]      side_o,
    output logic              done_o
);

    logic [W-1:0] acc_q, tmp_q, side_q;
    flags_t       flg_q, nf;
    logic         done_q;

    ctrl_t        ctrl;
    logic [W-1:0] sum, res;
    logic         co, co_nib;

    alu_decode #(.W(W)) u_dec (
        .op   (op_i),
        .acc  (acc_q),
        .tmp  (tmp_q),
        .cy   (flg_q.cy),
        .ctrl (ctrl)
    );

    alu_addsub #(.W(W), .N(N)) u_add (
        .a      (ctrl.a),
        .b      (ctrl.b),
        .sub    (ctrl.sub),
        .cin    (ctrl.cin),
        .sum    (sum),
        .co     (co),
        .co_nib (co_nib)
    );

    assign res = ctrl.is_logic ? logic_unit(ctrl.a, ctrl.b, ctrl.lop) : sum;

    alu_flagger #(.W(W)) u_flg (
        .res      (res),
        .co       (co),
        .co_nib   (co_nib),
        .is_logic (ctrl.is_logic),
        .keep_cy  (ctrl.keep_cy),
        .cy_old   (flg_q.cy),
        .nf       (nf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tmp_q  <= '0;
            side_q <= '0;
            flg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start_i;
            if (opnd_ld_i)
                tmp_q <= opnd_i;
            if (start_i && ctrl.wb != WB_NONE)
                flg_q <= nf;
            if (start_i && ctrl.wb == WB_ACC)
                acc_q <= res;
            if (start_i && ctrl.wb == WB_SIDE)
                side_q <= res;
        end
    end

    assign acc_o   = acc_q;
    assign flags_o = flg_q;
    assign side_o  = side_q;
    assign done_o  = done_q;

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(acc_o) && $stable(flags_o) && $stable(side_o)));

    // R4
    logic_clears_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && (op_i == 4'(OP_AND) || op_i == 4'(OP_XOR) || op_i == 4'(OP_OR)))
        |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0));

    // R5
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == 4'(OP_CMP)) |=> $stable(acc_o));

    // R6
    step_acc_keeps_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && (op_i == 4'(OP_INA) || op_i == 4'(OP_DCA)))
        |=> (flags_o[0] == $past(flags_o[0])));

    // R7
    step_side_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && (op_i == 4'(OP_INR) || op_i == 4'(OP_DCR)))
        |=> ($stable(acc_o) && flags_o[0] == $past(flags_o[0])));

    // R10
    reserved_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i >= 4'd12)
        |=> ($stable(acc_o) && $stable(flags_o) && $stable(side_o)));

endmodule

// File: tb/tb_acc_alu_top.sv
`timescale 1ns/1ps
module tb_acc_alu_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_i;
    logic [7:0] opnd_i;
    logic       opnd_ld_i;
    logic       start_i;
    logic [7:0] acc_o;
    logic [4:0] flags_o;
    logic [7:0] side_o;
    logic       done_o;

    always #4 clk = ~clk;   // 125 MHz

    acc_alu_top dut (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .opnd_i    (opnd_i),
        .opnd_ld_i (opnd_ld_i),
        .start_i   (start_i),
        .acc_o     (acc_o),
        .flags_o   (flags_o),
        .side_o    (side_o),
        .done_o    (done_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model state
    int m_acc, m_tmp, m_side;
    int m_s, m_z, m_ac, m_p, m_cy;

    function automatic int mflags();
        return (m_s << 4) | (m_z << 3) | (m_ac << 2) | (m_p << 1) | m_cy;
    endfunction

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic string tag_of(input int op);
        if (op <= 3)       return "R3 R8 R9";
        else if (op <= 6)  return "R4 R8";
        else if (op == 7)  return "R5 R9";
        else if (op <= 9)  return "R6 R9";
        else if (op <= 11) return "R7 R8 R9";
        else               return "R10";
    endfunction

    // integer reference for one operation
    task automatic model(input int op);
        int r, d, c;
        bit touch = 1;
        r = 0;
        case (op)
            0, 1: begin
                c = (op == 1) ? m_cy : 0;
                d = m_acc + m_tmp + c;
                m_ac = (((m_acc & 15) + (m_tmp & 15) + c) > 15);
                m_cy = (d > 255);
                r = d & 255; m_acc = r;
            end
            2, 3, 7: begin
                c = (op == 3) ? m_cy : 0;
                d = m_acc - m_tmp - c;
                m_ac = (((m_acc & 15) - (m_tmp & 15) - c) < 0);
                m_cy = (d < 0);
                r = d & 255;
                if (op != 7) m_acc = r;
            end
            4, 5, 6: begin
                r = (op == 4) ? (m_acc & m_tmp) : (op == 5) ? (m_acc ^ m_tmp) : (m_acc | m_tmp);
                m_cy = 0; m_ac = 0; m_acc = r;
            end
            8:  begin m_ac = ((m_acc & 15) == 15); r = (m_acc + 1) & 255; m_acc = r; end
            9:  begin m_ac = ((m_acc & 15) == 0);  r = (m_acc + 255) & 255; m_acc = r; end
            10: begin m_ac = ((m_tmp & 15) == 15); r = (m_tmp + 1) & 255; m_side = r; end
            11: begin m_ac = ((m_tmp & 15) == 0);  r = (m_tmp + 255) & 255; m_side = r; end
            default: touch = 0;
        endcase
        if (touch) begin
            m_s = (r >> 7) & 1;
            m_z = (r == 0);
            m_p = ((ones(r) % 2) == 0);
        end
    endtask

    // one operation: optional load cycle, start cycle, then check
    task automatic run_op(input int op, input int v, input bit do_load);
        if (do_load) begin
            opnd_i = 8'(v); opnd_ld_i = 1'b1;
            @(negedge clk);
            opnd_ld_i = 1'b0;
            m_tmp = v;
            // R2: loading alone leaves outputs unchanged, pulse already gone
            chk(acc_o == 8'(m_acc) && flags_o == 5'(mflags()) && done_o == 1'b0,
                "R2 load-only", {acc_o, flags_o, done_o}, {m_acc[7:0], mflags()[4:0], 1'b0});
        end
        op_i = 4'(op); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        model(op);
        chk(done_o == 1'b1, "R2 done", done_o, 1);
        chk(acc_o == 8'(m_acc) && flags_o == 5'(mflags()) && side_o == 8'(m_side),
            tag_of(op), {acc_o, 3'b0, flags_o, side_o},
            {m_acc[7:0], 3'b0, mflags()[4:0], m_side[7:0]});
    endtask

    task automatic clear_model();
        m_acc = 0; m_tmp = 0; m_side = 0;
        m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst = 1'b1; op_i = '0; opnd_i = '0; opnd_ld_i = 1'b0; start_i = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(acc_o == 0 && flags_o == 0 && side_o == 0 && done_o == 0, "R1 reset",
            {acc_o, flags_o, side_o, done_o}, 0);
        // R1: operand register cleared, step it without loading
        run_op(10, 0, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R2 pulse width", done_o, 0);

        // near-exhaustive chained sweep
        for (int rep = 0; rep < 6; rep++)
            for (int op = 0; op < 16; op++)
                for (int v = 0; v < 256; v++)
                    run_op(op, (v ^ (rep * 37)) & 255, 1);

        // directed corners: acc 0xFF + 1 -> 0, carry and nibble carry set
        run_op(4, 0, 1);  run_op(6, 255, 1); run_op(0, 1, 1);
        // subtract with borrow chain from carry=1
        run_op(2, 1, 1);  run_op(3, 0, 1);
        // compare equal -> zero, no borrow
        run_op(7, m_acc, 1);

        // R1: reset in the middle of an operation
        opnd_i = 8'h5A; opnd_ld_i = 1'b1; op_i = 4'd0; start_i = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; opnd_ld_i = 1'b0; start_i = 1'b0;
        clear_model();
        chk(acc_o == 0 && flags_o == 0 && side_o == 0 && done_o == 0, "R1 mid-run reset",
            {acc_o, flags_o, side_o, done_o}, 0);
        run_op(11, 0, 0);   // operand cleared: 0 - 1 = 0xFF on side port

        summary();
    end

endmodule